// File: doc/BRIEF.md
# Banked Dual-Write Register File

This block is a general-purpose register file that serves two operand reads and up to two result writes every cycle. It holds sixty-four 64-bit registers. Instead of one storage array with two write ports, it uses four banks of sixteen registers, and each bank has a single write port. The two low bits of a register number pick its bank, and the remaining bits pick the row inside that bank. Two writes can therefore both complete in the same cycle whenever they land in different banks.

When two valid writes target different registers in the same bank, write port 0 is committed. Port 1 is refused, and the block raises a stall flag in the same cycle, together with the unit tag of the refused request. The scheduler must keep that request presented and retry it on the next cycle. When both ports name the very same register, the block raises an error flag, keeps port 0's data and drops port 1 without a stall.

A paired mode serves instructions that produce two results. In this mode, port 1's target is derived as port 0's register number with bit 0 inverted. The two targets are then always in different banks, so a paired write never stalls. Register 0 is hard-wired to zero.

Top module: `bank_regfile`

## Requirements
- R1: A granted write of data D to register r (r nonzero) makes both read ports return D for address r from the cycle after the write edge onward, until r is written again. Register r lives in bank r[1:0], at row r[5:2].
- R2: After reset, every register reads as zero on both read ports.
- R3: Register 0 always reads as zero. A write to register 0 is discarded and does not count as a bank user when conflicts are decided.
- R4: Two valid writes whose register numbers differ in bits [1:0] both commit at the same clock edge, and neither stall nor error is raised.
- R5: Two valid writes to different registers with equal bits [1:0] commit only port 0. In that same cycle, wr1_stall is 1 and stall_unit equals wr1_unit. Port 1's data is not written.
- R6: stall_unit is zero whenever wr1_stall is 0. A stall is raised only when both ports carry a valid write.
- R7: Two valid writes to the same register raise wr_clash in that cycle and keep port 0's data. Port 1 is dropped, and wr1_stall stays 0.
- R8: With pair_mode at 1, port 1's target is wr0_addr with bit 0 inverted, and wr1_addr is ignored. Port 1's enable and data are still used. wr1_stall and wr_clash stay 0 in this mode.
- R9: Reads are combinational. A read of a register that is being written in the same cycle returns the value held before that write.
- R10: The two read ports are independent: each port returns the contents of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| pair_mode | input | 1 | Two-result mode: port 1 target becomes wr0_addr xor 1 |
| wr0_en | input | 1 | Write port 0 request valid |
| wr0_addr | input | 6 | Write port 0 register number |
| wr0_data | input | 64 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 request valid |
| wr1_addr | input | 6 | Write port 1 register number (ignored in pair mode) |
| wr1_unit | input | 3 | Tag of the unit driving write port 1 |
| wr1_data | input | 64 | Write port 1 data |
| rd0_addr | input | 6 | Read port 0 register number |
| rd0_data | output | 64 | Read port 0 data, combinational |
| rd1_addr | input | 6 | Read port 1 register number |
| rd1_data | output | 64 | Read port 1 data, combinational |
| wr1_stall | output | 1 | Port 1 refused for a bank conflict this cycle; retry next cycle |
| stall_unit | output | 3 | Unit tag of the refused port 1 request, zero otherwise |
| wr_clash | output | 1 | Both ports named the same register this cycle |

## Verification
A wrong arbitration decision shows up at once, in the same cycle, as an incorrect wr1_stall, stall_unit or wr_clash. A wrong bank or row selection, a lost write, or a write that went to the wrong port's data shows up one cycle later: reading the affected register then returns a value that differs from the running model. The read ports are compared against that model on every cycle of the sweeps. Because a read of a register that is being written in the same cycle must show the old contents, a write that takes effect too early is caught in the cycle it happens.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_ONLY0,
    WR_ONLY1,
    WR_BOTH,
    WR_STALL,
    WR_CLASH
  } wr_outcome_e;

  // Decide what happens to the two write requests this cycle.
  function automatic wr_outcome_e classify(input logic v0, input logic v1,
                                           input logic same_bank,
                                           input logic same_reg);
    wr_outcome_e r;
    if (!v0 && !v1)      r = WR_NONE;
    else if (!v1)        r = WR_ONLY0;
    else if (!v0)        r = WR_ONLY1;
    else if (same_reg)   r = WR_CLASH;
    else if (same_bank)  r = WR_STALL;
    else                 r = WR_BOTH;
    return r;
  endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int ROWS = 16,
  parameter int DW   = 64,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wrow,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] rrow0,
  input  logic [RW-1:0] rrow1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[wrow] <= wdata;
    end
  end

  assign rdata0 = mem[rrow0];
  assign rdata1 = mem[rrow1];

endmodule

// File: rtl/rf_wr_arbiter.sv
module rf_wr_arbiter
  import rf_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NBANK = 4,
  parameter int UW    = 3,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             pair_mode,
  input  logic             en0,
  input  logic [AW-1:0]    a0,
  input  logic             en1,
  input  logic [AW-1:0]    a1_req,
  input  logic [UW-1:0]    unit1,
  output logic [AW-1:0]    a1_eff,
  output logic             grant0,
  output logic             grant1,
  output logic             stall,
  output logic             clash,
  output logic [UW-1:0]    stall_unit,
  output logic [NBANK-1:0] hit0,
  output logic [NBANK-1:0] hit1,
  output wr_outcome_e      outcome
);

  logic v0, v1, same_bank, same_reg;

  always_comb begin
    a1_eff    = pair_mode ? (a0 ^ AW'(1)) : a1_req;
    v0        = en0 && (a0 != '0);
    v1        = en1 && (a1_eff != '0);
    same_bank = (a0[BW-1:0] == a1_eff[BW-1:0]);
    same_reg  = (a0 == a1_eff);
    outcome   = classify(v0, v1, same_bank, same_reg);
    grant0    = (outcome == WR_ONLY0) || (outcome == WR_BOTH) ||
                (outcome == WR_STALL) || (outcome == WR_CLASH);
    grant1    = (outcome == WR_ONLY1) || (outcome == WR_BOTH);
    stall     = (outcome == WR_STALL);
    clash     = (outcome == WR_CLASH);
    stall_unit = stall ? unit1 : '0;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_hit
    assign hit0[b] = grant0 && (a0[BW-1:0] == BW'(b));
    assign hit1[b] = grant1 && (a1_eff[BW-1:0] == BW'(b));
  end

endmodule

// File: rtl/rf_rd_sel.sv
module rf_rd_sel #(
  parameter int AW    = 6,
  parameter int NBANK = 4,
  parameter int DW    = 64,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [AW-1:0]             addr,
  input  logic [NBANK-1:0][DW-1:0]  bank_q,
  output logic [DW-1:0]             data
);

  always_comb begin
    if (addr == '0) data = '0;
    else            data = bank_q[addr[BW-1:0]];
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import rf_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int DW    = 64,
  parameter int NBANK = 4,
  parameter int UW    = 3,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(NBANK),
  localparam int ROWS = NREG / NBANK,
  localparam int RW   = AW - BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_mode,
  input  logic          wr0_en,
  input  logic [AW-1:0] wr0_addr,
  input  logic [DW-1:0] wr0_data,
  input  logic          wr1_en,
  input  logic [AW-1:0] wr1_addr,
  input  logic [UW-1:0] wr1_unit,
  input  logic [DW-1:0] wr1_data,
  input  logic [AW-1:0] rd0_addr,
  output logic [DW-1:0] rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd1_data,
  output logic          wr1_stall,
  output logic [UW-1:0] stall_unit,
  output logic          wr_clash
);

  // Named internal events, visible to the bound checker.
  logic [AW-1:0]    port1_addr_eff;
  logic             port0_grant;
  logic             port1_grant;
  logic [NBANK-1:0] bank_hit0;
  logic [NBANK-1:0] bank_hit1;
  wr_outcome_e      wr_outcome;

  logic [NBANK-1:0][DW-1:0] bank_q0;
  logic [NBANK-1:0][DW-1:0] bank_q1;

  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:BW];
  endfunction

  rf_wr_arbiter #(.AW(AW), .NBANK(NBANK), .UW(UW)) u_arb (
    .pair_mode  (pair_mode),
    .en0        (wr0_en),
    .a0         (wr0_addr),
    .en1        (wr1_en),
    .a1_req     (wr1_addr),
    .unit1      (wr1_unit),
    .a1_eff     (port1_addr_eff),
    .grant0     (port0_grant),
    .grant1     (port1_grant),
    .stall      (wr1_stall),
    .clash      (wr_clash),
    .stall_unit (stall_unit),
    .hit0       (bank_hit0),
    .hit1       (bank_hit1),
    .outcome    (wr_outcome)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          we;
    logic [RW-1:0] wrow;
    logic [DW-1:0] wdata;

    // Port 0 has priority on the bank write port.
    always_comb begin
      we    = bank_hit0[b] || bank_hit1[b];
      wrow  = bank_hit0[b] ? row_of(wr0_addr) : row_of(port1_addr_eff);
      wdata = bank_hit0[b] ? wr0_data : wr1_data;
    end

    rf_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .wrow   (wrow),
      .wdata  (wdata),
      .rrow0  (row_of(rd0_addr)),
      .rrow1  (row_of(rd1_addr)),
      .rdata0 (bank_q0[b]),
      .rdata1 (bank_q1[b])
    );
  end

  rf_rd_sel #(.AW(AW), .NBANK(NBANK), .DW(DW)) u_rd0 (
    .addr   (rd0_addr),
    .bank_q (bank_q0),
    .data   (rd0_data)
  );

  rf_rd_sel #(.AW(AW), .NBANK(NBANK), .DW(DW)) u_rd1 (
    .addr   (rd1_addr),
    .bank_q (bank_q1),
    .data   (rd1_data)
  );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NREG  = 64,
  parameter int DW    = 64,
  parameter int NBANK = 4,
  parameter int UW    = 3,
  localparam int AW   = $clog2(NREG),
  localparam int BW   = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pair_mode,
  input logic [AW-1:0]    wr0_addr,
  input logic [DW-1:0]    wr0_data,
  input logic [UW-1:0]    wr1_unit,
  input logic [AW-1:0]    rd0_addr,
  input logic [DW-1:0]    rd0_data,
  input logic [AW-1:0]    rd1_addr,
  input logic [DW-1:0]    rd1_data,
  input logic             wr1_stall,
  input logic [UW-1:0]    stall_unit,
  input logic             wr_clash,
  input logic             port0_grant,
  input logic             port1_grant,
  input logic [AW-1:0]    port1_addr_eff,
  input logic [NBANK-1:0] bank_hit0,
  input logic [NBANK-1:0] bank_hit1
);

  AST_PORT0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(port0_grant) && rd0_addr == $past(wr0_addr))
      |-> rd0_data == $past(wr0_data)); // R1

  AST_ZERO_READ0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == '0) |-> (rd0_data == '0)); // R3

  AST_ZERO_READ1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == '0) |-> (rd1_data == '0)); // R3

  AST_BANK_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_hit0 & bank_hit1) == '0) && $onehot0(bank_hit0) && $onehot0(bank_hit1)); // R4

  AST_STALL_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_stall |-> (port0_grant && !port1_grant &&
                   port1_addr_eff[BW-1:0] == wr0_addr[BW-1:0] &&
                   port1_addr_eff != wr0_addr)); // R5

  AST_STALL_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_stall |-> (stall_unit == wr1_unit)); // R5

  AST_IDLE_UNIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr1_stall |-> (stall_unit == '0)); // R6

  AST_CLASH_KEEPS_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clash |-> (port0_grant && !port1_grant && !wr1_stall &&
                  port1_addr_eff == wr0_addr)); // R7

  AST_PAIR_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode |-> (!wr1_stall && !wr_clash &&
                   port1_addr_eff == (wr0_addr ^ AW'(1)))); // R8

endmodule

bind bank_regfile rf_checker #(
  .NREG(NREG), .DW(DW), .NBANK(NBANK), .UW(UW)
) u_rf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pair_mode      (pair_mode),
  .wr0_addr       (wr0_addr),
  .wr0_data       (wr0_data),
  .wr1_unit       (wr1_unit),
  .rd0_addr       (rd0_addr),
  .rd0_data       (rd0_data),
  .rd1_addr       (rd1_addr),
  .rd1_data       (rd1_data),
  .wr1_stall      (wr1_stall),
  .stall_unit     (stall_unit),
  .wr_clash       (wr_clash),
  .port0_grant    (port0_grant),
  .port1_grant    (port1_grant),
  .port1_addr_eff (port1_addr_eff),
  .bank_hit0      (bank_hit0),
  .bank_hit1      (bank_hit1)
);

// File: tb/tb_bank_regfile.sv
`timescale 1ns/1ps
module tb_bank_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pair_mode;
  logic        wr0_en, wr1_en;
  logic [5:0]  wr0_addr, wr1_addr, rd0_addr, rd1_addr;
  logic [63:0] wr0_data, wr1_data, rd0_data, rd1_data;
  logic [2:0]  wr1_unit, stall_unit;
  logic        wr1_stall, wr_clash;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] model [64];

  always #2 clk = ~clk;   // 250 MHz

  bank_regfile dut (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_unit(wr1_unit), .wr1_data(wr1_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr1_stall(wr1_stall), .stall_unit(stall_unit), .wr_clash(wr_clash)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Reads compared against the model before this cycle's writes land (R9, R10, R3).
  task automatic check_reads();
    chk(rd0_addr == 0 ? "R3 port0 zero register" : "R9 port0 old value", rd0_data, model[rd0_addr]);
    chk(rd1_addr == 0 ? "R3 port1 zero register" : "R10 port1 independent read", rd1_data, model[rd1_addr]);
  endtask

  initial begin
    rst_n = 1'b0; pair_mode = 1'b0;
    wr0_en = 1'b0; wr1_en = 1'b0;
    wr0_addr = '0; wr1_addr = '0; wr0_data = '0; wr1_data = '0; wr1_unit = '0;
    rd0_addr = '0; rd1_addr = '0;
    for (int r = 0; r < 64; r++) model[r] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: all registers clear after reset
    for (int r = 0; r < 64; r++) begin
      @(negedge clk);
      rd0_addr = 6'(r); rd1_addr = 6'(63 - r);
      #1;
      chk("R2 reset port0", rd0_data, 64'd0);
      chk("R2 reset port1", rd1_data, 64'd0);
    end
    chk("R6 no stall at idle", {63'd0, wr1_stall}, 64'd0);

    // Full sweep of address pairs with both ports enabled.
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        logic v0, v1, exp_stall, exp_clash;
        @(negedge clk);
        wr0_en = 1'b1; wr1_en = 1'b1;
        wr0_addr = 6'(i); wr1_addr = 6'(j);
        wr0_data = {8'hA5, 8'(i), 8'(j), 8'h01, ~32'(i * 64 + j)};
        wr1_data = {8'h5A, 8'(j), 8'(i), 8'h02, 32'(i * 64 + j)};
        wr1_unit = 3'((i + j) % 8);
        rd0_addr = 6'(i); rd1_addr = 6'(j);
        #1;
        v0 = (i != 0); v1 = (j != 0);
        exp_clash = v0 && v1 && (i == j);
        exp_stall = v0 && v1 && (i != j) && ((i % 4) == (j % 4));
        chk(exp_stall ? "R5 stall raised" : "R4 R3 no stall", {63'd0, wr1_stall}, {63'd0, exp_stall});
        chk(exp_stall ? "R5 stall unit" : "R6 stall unit zero", {61'd0, stall_unit},
            exp_stall ? {61'd0, 3'((i + j) % 8)} : 64'd0);
        chk("R7 clash flag", {63'd0, wr_clash}, {63'd0, exp_clash});
        check_reads();
        if (v0) model[i] = wr0_data;
        if (v1 && !exp_stall && !exp_clash) model[j] = wr1_data;
      end
    end

    // Paired mode: port 1 target is wr0_addr xor 1; wr1_addr is ignored.
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      pair_mode = 1'b1;
      wr0_en = 1'b1; wr1_en = 1'b1;
      wr0_addr = 6'(n); wr1_addr = 6'(63 - n);
      wr0_data = {32'hC0DE0000 | 32'(n), 32'(n * 3)};
      wr1_data = {32'hBEEF0000 | 32'(n), 32'(n * 5)};
      wr1_unit = 3'(n % 8);
      rd0_addr = 6'(n); rd1_addr = 6'(n ^ 1);
      #1;
      chk("R8 pair no stall", {63'd0, wr1_stall}, 64'd0);
      chk("R8 pair no clash", {63'd0, wr_clash}, 64'd0);
      check_reads();
      if (n != 0) model[n] = wr0_data;
      if ((n ^ 1) != 0) model[n ^ 1] = wr1_data;
    end
    @(negedge clk);
    pair_mode = 1'b0;

    // Port 1 alone in a bank port 0 would use: no stall without a second writer.
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      wr0_en = 1'b0; wr1_en = 1'b1;
      wr0_addr = 6'(n); wr1_addr = 6'(n ^ 4);
      wr1_data = {32'h0F0F0000 | 32'(n), 32'(n * 7)};
      wr1_unit = 3'(7 - (n % 8));
      rd0_addr = 6'(n ^ 4); rd1_addr = 6'(n);
      #1;
      chk("R6 single writer no stall", {63'd0, wr1_stall}, 64'd0);
      chk("R6 single writer unit zero", {61'd0, stall_unit}, 64'd0);
      check_reads();
      if ((n ^ 4) != 0) model[n ^ 4] = wr1_data;
    end

    // Final readback of all registers on both ports.
    @(negedge clk);
    wr0_en = 1'b0; wr1_en = 1'b0;
    for (int r = 0; r < 64; r++) begin
      @(negedge clk);
      rd0_addr = 6'(r); rd1_addr = 6'(63 - r);
      #1;
      chk("R1 final contents port0", rd0_data, model[r]);
      chk("R1 final contents port1", rd1_data, model[63 - r]);
    end

    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

endmodule